// File: doc/BRIEF.md
# Debug Coprocessor Register Access Chain

This block is a 48-bit data register that sits behind a test access port controller. An external debugger uses it to read and write internal coprocessor control registers. The debugger shifts a command into the chain. The command holds a direction bit, a 14-bit register selector, a 32-bit data word and one control bit. When the update strobe arrives with the control bit set, the block starts one access on a request/acknowledge port toward the register file.

The same control bit is read back during the next capture as the access-complete flag. The debugger polls with scans that carry the control bit at 0. When the flag reads 1 after a read, the data word holds the value that was read. A scan with the control bit at 0 while no access is outstanding leaves the chain untouched. A value shifted in by such a scan is therefore returned unchanged by the next capture and shift, so the data word can be preset by one scan before a later scan starts the access.

The surrounding controller state machine and instruction decoding are outside the block. They supply a chain-select level and single-cycle capture, shift and update strobes that are synchronous to the block clock.

Top module: `dcr_scan_chain`

## Requirements
- R1: After reset, tdo is 0, req is 0 and the first capture and shift returns all 48 bits as 0.
- R2: While selected, each shift cycle moves the chain one place toward bit 0, with tdi entering bit 47 and tdo showing bit 0. Forty-eight shifts therefore return the 48 bits LSB first.
- R3: The chain layout is: bit 47 = write (1) / read (0); bits 46:44 group; 43:41 subgroup; 40:37 major index; 36:33 minor index; bit 32 control; bits 31:0 data. The addr output equals chain bits 46:33 with bit 46 as addr[13].
- R4: An update with bit 32 = 1 while idle raises req in the next cycle, with we, addr and wdata taken from the chain.
- R5: For a read request (bit 47 = 0), wdata is driven as 0 whatever the data field holds.
- R6: req stays high with we, addr and wdata stable until ack is sampled high, and req is low in the cycle after that ack.
- R7: A capture while an access is outstanding loads bit 32 as 0 and keeps the other 47 bits.
- R8: A capture after completion loads bit 32 as 1. After a read, the first such capture also loads bits 31:0 with the rdata value that was sampled with ack.
- R9: An update with bit 32 = 0 starts nothing and leaves the chain unchanged. With no access outstanding, the next capture and shift return the same data and upper bits.
- R10: An update with bit 32 = 1 while an access is outstanding is ignored: no second request, and addr, we and wdata keep their values.
- R11: While the chain select is low, capture, shift and update strobes have no effect on the chain or on req.
- R12: The complete flag stays 1 across any number of captures and clears only when the next access is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | This chain is the selected data register |
| cap_dr | input | 1 | Capture strobe, one cycle |
| shift_dr | input | 1 | Shift strobe, one cycle per bit |
| upd_dr | input | 1 | Update strobe, one cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, chain bit 0 |
| req | output | 1 | Register access request |
| we | output | 1 | Access is a write |
| addr | output | 14 | Register selector |
| wdata | output | 32 | Write data, 0 for reads |
| ack | input | 1 | Register access acknowledge |
| rdata | input | 32 | Read data, valid with ack |

## Verification
The bench builds the block with its default 32-bit data word and the fixed 14-bit selector, which gives the full 48-bit chain. Every scan is therefore a complete 48-shift sequence. Each field boundary, including the control bit between the data word and the selector, is exercised at its real position. A bench responder with adjustable latency and a hold switch keeps an access outstanding for as long as needed. This brings the busy capture, the ignored second start and the preset-then-recirculate path within reach.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int GRP_W = 3;
    localparam int SUB_W = 3;
    localparam int MAJ_W = 4;
    localparam int MIN_W = 4;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [SUB_W-1:0] sub;
        logic [MAJ_W-1:0] maj;
        logic [MIN_W-1:0] mnr;
    } sel_t;

    localparam int SEL_W = $bits(sel_t);

    typedef struct packed {
        logic wr;
        sel_t sel;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    function automatic int chain_width(input int data_w);
        return data_w + 1 + CMD_W;
    endfunction

endpackage

// File: rtl/dcr_shift.sv
module dcr_shift #(
    parameter int DATA_W  = 32,
    parameter int CHAIN_W = dcr_pkg::chain_width(32)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_cap,
    input  logic               en_shift,
    input  logic               tdi,
    input  logic               busy,
    input  logic               done,
    input  logic               load_rd,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [CHAIN_W-1:0] chain,
    output logic               tdo
);
    localparam int CTL = DATA_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (en_cap) begin
            if (busy) begin
                chain[CTL] <= 1'b0;
            end else begin
                chain[CTL] <= done;
                if (load_rd) begin
                    chain[DATA_W-1:0] <= rd_data;
                end
            end
        end else if (en_shift) begin
            chain <= {tdi, chain[CHAIN_W-1:1]};
        end
    end

    assign tdo = chain[0];

    AST_CAP_BUSY: assert property (@(posedge clk) disable iff (rst)
        en_cap && busy |=> !chain[CTL] && chain[CHAIN_W-1:CTL+1] == $past(chain[CHAIN_W-1:CTL+1])
            && chain[DATA_W-1:0] == $past(chain[DATA_W-1:0])) else $error("cap busy"); // R7
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        en_shift && !en_cap |=> chain[CHAIN_W-1] == $past(tdi)
            && chain[CHAIN_W-2:0] == $past(chain[CHAIN_W-1:1])) else $error("shift"); // R2
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_cap && !en_shift |=> $stable(chain)) else $error("hold"); // R9

endmodule

// File: rtl/dcr_access.sv
module dcr_access #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  dcr_pkg::cmd_t             cmd_in,
    input  logic [DATA_W-1:0]         data_in,
    input  logic                      cap_idle,
    input  logic                      ack,
    input  logic [DATA_W-1:0]         rdata,
    output logic                      req,
    output logic                      we,
    output logic [dcr_pkg::SEL_W-1:0] addr,
    output logic [DATA_W-1:0]         wdata,
    output logic                      busy,
    output logic                      done,
    output logic                      fresh,
    output logic [DATA_W-1:0]         rd_q
);
    dcr_pkg::cmd_t     cmd_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;
    logic              finish;

    assign accept = start && !busy;
    assign finish = busy && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            fresh   <= 1'b0;
            cmd_q   <= '0;
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                busy    <= 1'b1;
                done    <= 1'b0;
                fresh   <= 1'b0;
                cmd_q   <= cmd_in;
                wdata_q <= cmd_in.wr ? data_in : '0;
            end else if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
                if (!cmd_q.wr) begin
                    rd_q  <= rdata;
                    fresh <= 1'b1;
                end
            end else if (cap_idle) begin
                fresh <= 1'b0;
            end
        end
    end

    assign req   = busy;
    assign we    = cmd_q.wr;
    assign addr  = cmd_q.sel;
    assign wdata = wdata_q;

    AST_START_REQ: assert property (@(posedge clk) disable iff (rst)
        start && !req |=> req) else $error("start"); // R4
    AST_RD_WDATA: assert property (@(posedge clk) disable iff (rst)
        req && !we |-> wdata == '0) else $error("rd wdata"); // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && $stable(we) && $stable(addr) && $stable(wdata)) else $error("hold"); // R6
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        req && ack |=> !req && done) else $error("ack drop"); // R6
    AST_DONE_KEEP: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done) else $error("done keep"); // R12

endmodule

// File: rtl/dcr_scan_chain.sv
module dcr_scan_chain #(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      chain_sel,
    input  logic                      cap_dr,
    input  logic                      shift_dr,
    input  logic                      upd_dr,
    input  logic                      tdi,
    output logic                      tdo,
    output logic                      req,
    output logic                      we,
    output logic [dcr_pkg::SEL_W-1:0] addr,
    output logic [DATA_W-1:0]         wdata,
    input  logic                      ack,
    input  logic [DATA_W-1:0]         rdata
);
    localparam int CHAIN_W = dcr_pkg::chain_width(DATA_W);
    localparam int CTL     = DATA_W;

    logic [CHAIN_W-1:0] chain;
    logic               en_cap;
    logic               en_shift;
    logic               en_upd;
    logic               start;
    logic               busy;
    logic               done;
    logic               fresh;
    logic [DATA_W-1:0]  rd_q;
    dcr_pkg::cmd_t      cmd;

    assign en_cap   = chain_sel && cap_dr;
    assign en_shift = chain_sel && shift_dr && !cap_dr;
    assign en_upd   = chain_sel && upd_dr;
    assign start    = en_upd && chain[CTL];
    assign cmd      = dcr_pkg::cmd_t'(chain[CHAIN_W-1:CTL+1]);

    dcr_shift #(.DATA_W(DATA_W), .CHAIN_W(CHAIN_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .en_cap   (en_cap),
        .en_shift (en_shift),
        .tdi      (tdi),
        .busy     (busy),
        .done     (done),
        .load_rd  (fresh),
        .rd_data  (rd_q),
        .chain    (chain),
        .tdo      (tdo)
    );

    dcr_access #(.DATA_W(DATA_W)) u_access (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd_in   (cmd),
        .data_in  (chain[DATA_W-1:0]),
        .cap_idle (en_cap && !busy),
        .ack      (ack),
        .rdata    (rdata),
        .req      (req),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .busy     (busy),
        .done     (done),
        .fresh    (fresh),
        .rd_q     (rd_q)
    );

    AST_UNSEL_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !chain_sel |=> !$rose(req)) else $error("unsel"); // R11
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        req && !ack && upd_dr |=> $stable(addr) && $stable(we)) else $error("busy start"); // R10

endmodule

// File: tb/dcr_scan_chain_test.sv
module dcr_scan_chain_test;
    localparam int DW = 32;

    logic clk = 0, rst = 1;
    logic chain_sel = 0, cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0;
    logic tdo, req, we, ack = 0;
    logic [13:0] addr;
    logic [DW-1:0] wdata, rdata = '0;

    int errors = 0, checks = 0;
    bit finished = 0;

    int nreq = 0, stab_err = 0, lat = 2, cnt = 0;
    bit hold_ack = 0, req_seen = 0;
    logic rec_we;
    logic [13:0] rec_addr;
    logic [DW-1:0] rec_wdata, rd_val = '0;

    always #2 clk = ~clk;

    dcr_scan_chain #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .chain_sel(chain_sel), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
        .req(req), .we(we), .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input logic wr, input logic [2:0] g, input logic [2:0] s,
                                       input logic [3:0] ma, input logic [3:0] mi,
                                       input logic ctl, input logic [31:0] d);
        return {wr, g, s, ma, mi, ctl, d};
    endfunction

    // register-side responder with latency and hold control
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                ack = 0; cnt = 0; req_seen = 0;
            end else if (ack) begin
                ack = 0; cnt = 0;
                if (req) stab_err++;            // R6: req must drop after ack
            end else if (req) begin
                if (!req_seen) begin
                    nreq++; rec_we = we; rec_addr = addr; rec_wdata = wdata;
                end else if (we !== rec_we || addr !== rec_addr || wdata !== rec_wdata) begin
                    stab_err++;                 // R6: fields stable while pending
                end
                if (!hold_ack) begin
                    if (cnt >= lat) begin ack = 1; rdata = rd_val; end
                    else cnt++;
                end
            end
            req_seen = req && !ack;
        end
    end

    task automatic scan(input logic [47:0] din, input logic s, output logic [47:0] dout);
        @(negedge clk); chain_sel = s; cap_dr = 1;
        @(negedge clk); cap_dr = 0;
        for (int i = 0; i < 48; i++) begin
            dout[i] = tdo; tdi = din[i]; shift_dr = 1;
            @(negedge clk);
        end
        shift_dr = 0; upd_dr = 1;
        @(negedge clk); upd_dr = 0; chain_sel = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    logic [47:0] dout, nop_a, wr_cmd, pend_cmd;

    task automatic t_reset;
        chk("R1 tdo", 64'(tdo), 0);
        chk("R1 req", 64'(req), 0);
        scan(48'h0, 1, dout);
        chk("R1 chain", 64'(dout), 0);
    endtask

    task automatic t_nop_recirc;
        logic [47:0] p;
        int n0;
        n0 = nreq;
        p = mk(1, 3'h5, 3'h2, 4'hA, 4'h3, 0, 32'hA5C3_0F96);
        scan(p, 1, dout);
        idle(6);
        chk("R9 no req", 64'(nreq - n0), 0);
        scan(48'h0, 1, dout);
        chk("R2 R9 recirc", 64'(dout), 64'(p));
    endtask

    task automatic t_write;
        int n0;
        n0 = nreq; lat = 3;
        wr_cmd = mk(1, 3'h6, 3'h1, 4'h9, 4'hC, 1, 32'hDEAD_BEEF);
        scan(wr_cmd, 1, dout);
        chk("R4 req", 64'(req), 1);
        idle(10);
        chk("R4 count", 64'(nreq - n0), 1);
        chk("R4 we", 64'(rec_we), 1);
        chk("R3 addr", 64'(rec_addr), 64'({3'h6, 3'h1, 4'h9, 4'hC}));
        chk("R4 wdata", 64'(rec_wdata), 64'(32'hDEAD_BEEF));
        chk("R6 drop", 64'(req), 0);
        nop_a = mk(0, 0, 0, 0, 0, 0, 32'h0);
        scan(nop_a, 1, dout);
        chk("R8 wr done", 64'(dout[32]), 1);
        chk("R8 wr data kept", 64'(dout[31:0]), 64'(32'hDEAD_BEEF));
        chk("R3 upper kept", 64'(dout[47:33]), 64'(wr_cmd[47:33]));
    endtask

    task automatic t_read;
        logic [47:0] c, n1;
        lat = 0; rd_val = 32'h5EED_1234;
        c = mk(0, 3'h1, 3'h7, 4'h2, 4'hF, 1, 32'hFFFF_FFFF);
        scan(c, 1, dout);
        chk("R5 wdata zero", 64'(wdata), 0);
        idle(6);
        chk("R5 we", 64'(rec_we), 0);
        chk("R5 rec wdata", 64'(rec_wdata), 0);
        chk("R3 rd addr", 64'(rec_addr), 64'({3'h1, 3'h7, 4'h2, 4'hF}));
        n1 = mk(0, 3'h2, 3'h3, 4'h4, 4'h5, 0, 32'h1234_5678);
        scan(n1, 1, dout);
        chk("R8 rd done", 64'(dout[32]), 1);
        chk("R8 rd data", 64'(dout[31:0]), 64'(32'h5EED_1234));
        scan(48'h0, 1, dout);
        chk("R12 done held", 64'(dout[32]), 1);
        chk("R9 data after read", 64'(dout[31:0]), 64'(32'h1234_5678));
        chk("R9 upper after read", 64'(dout[47:33]), 64'(n1[47:33]));
    endtask

    task automatic t_pending;
        logic [47:0] c2;
        int n0;
        n0 = nreq; hold_ack = 1;
        pend_cmd = mk(1, 3'h3, 3'h4, 4'h1, 4'h7, 1, 32'hCAFE_0001);
        scan(pend_cmd, 1, dout);
        idle(4);
        c2 = mk(1, 3'h7, 3'h7, 4'hE, 4'hE, 1, 32'h0BAD_0BAD);
        scan(c2, 1, dout);
        chk("R7 busy flag", 64'(dout[32]), 0);
        chk("R7 upper kept", 64'(dout[47:33]), 64'(pend_cmd[47:33]));
        chk("R7 data kept", 64'(dout[31:0]), 64'(32'hCAFE_0001));
        idle(3);
        chk("R10 addr", 64'(addr), 64'({3'h3, 3'h4, 4'h1, 4'h7}));
        chk("R10 wdata", 64'(wdata), 64'(32'hCAFE_0001));
        hold_ack = 0;
        idle(10);
        chk("R10 one req", 64'(nreq - n0), 1);
        chk("R6 stable", 64'(stab_err), 0);
        scan(48'h0, 1, dout);
        chk("R8 pend done", 64'(dout[32]), 1);
    endtask

    task automatic t_done_clear;
        hold_ack = 1;
        scan(mk(1, 3'h0, 3'h5, 4'h6, 4'h8, 1, 32'h7777_0000), 1, dout);
        nop_a = mk(0, 3'h4, 3'h4, 4'h4, 4'h4, 0, 32'h0F0F_1E1E);
        scan(nop_a, 1, dout);
        chk("R12 cleared on start", 64'(dout[32]), 0);
        hold_ack = 0;
        idle(10);
    endtask

    task automatic t_unsel;
        int n0;
        n0 = nreq;
        scan(mk(1, 3'h7, 3'h0, 4'h3, 4'h3, 1, 32'h9999_9999), 0, dout);
        idle(6);
        chk("R11 no req", 64'(nreq - n0), 0);
        chk("R11 req low", 64'(req), 0);
        scan(48'h0, 1, dout);
        chk("R11 data kept", 64'(dout[31:0]), 64'(32'h0F0F_1E1E));
        chk("R11 upper kept", 64'(dout[47:33]), 64'(nop_a[47:33]));
        chk("R12 done still", 64'(dout[32]), 1);
    endtask

    initial begin
        idle(4);
        rst = 0;
        @(negedge clk);
        t_reset;
        t_nop_recirc;
        t_write;
        t_read;
        t_pending;
        t_done_clear;
        t_unsel;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule